// File: doc/BRIEF.md
# Dual-Channel IDE I/O Address Decoder

This block turns host I/O addresses into chip selects for a two-channel IDE controller. It holds a small set of configuration bytes at their standard configuration-space offsets: command, status high byte, programming interface, the five base-address words and a general control byte. From these bytes it works out, for each channel, whether an I/O cycle falls on the 8-port command block, on the single control port, or on the 8-port bus-master register window.

Each channel uses either its fixed legacy addresses or a relocatable native base taken from its own base-address registers, and the two channels choose independently. Command and control decoding needs a global I/O enable and the channel's own enable bit. The bus-master windows need only the bus-master enable. Software writes and reads the configuration bytes through a byte-wide port with a combinational read path. The drive protocol, the DMA engine and interrupt routing are handled elsewhere.

Top module: `ide_io_decode`

## Requirements
- R1: After reset every configuration byte reads as zero and no chip select is asserted.
- R2: Command-block and control-port selects for both channels stay low unless bit 0 of the command byte (offset 0x04) is set.
- R3: Bit 2 of the general control byte (offset 0x4A) enables the primary channel (index 0). Bit 1 of that byte enables the secondary channel (index 1).
- R4: When programming-interface bit 0 (primary) or bit 2 (secondary) at offset 0x09 is clear, the channel uses legacy decoding. The primary channel then selects 0x1F0..0x1F7 and control port 0x3F6. The secondary channel selects 0x170..0x177 and control port 0x376.
- R5: In native mode the command block is the 8 ports starting at the 16-bit little-endian word at offset 0x10 (primary) or 0x18 (secondary), with its low 3 bits cleared.
- R6: In native mode the control port is the word at offset 0x14 (primary) or 0x1C (secondary) with its low 2 bits cleared, plus 2. It is exactly one port.
- R7: The bus-master base is the word at offset 0x20 with its low 4 bits cleared. The primary window is base..base+7 and the secondary window is base+8..base+15. Both decode only while bit 2 of the command byte is set, regardless of the bit 0 and channel enables.
- R8: Each select is registered. It is high in the cycle after a clock edge that sampled the strobe high on a matching address, and it is low after any edge that sampled the strobe low. Decoding uses the configuration held before that edge.
- R9: A command write keeps only bits 0 and 2. A general control write is masked with 0x9F. The programming-interface byte and the base-address bytes 0x10..0x23 store the full byte. All other offsets ignore writes and read as zero.
- R10: The status high byte (offset 0x07) sets bits from the `stat_set` input. Writing a 1 clears that bit, but only for bits 5:0. A set takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| stat_set | input | 8 | Status event bits, set into the status high byte |
| io_addr | input | 16 | I/O cycle address |
| io_strobe | input | 1 | I/O cycle valid |
| cmd_cs | output | 2 | Command-block select per channel |
| ctl_cs | output | 2 | Control-port select per channel |
| bm_cs | output | 2 | Bus-master window select per channel |

## Verification
A select is due one cycle after the strobe. It reflects the configuration that was in force at the edge that sampled the strobe. Configuration reads are due in the same cycle as the address. A configuration write or status event becomes visible after one edge. The bench keeps a behavioural model that is updated at every rising edge with the same inputs the design sampled. It compares all six selects and the read data one nanosecond after that edge, before the next input change at the falling edge. Directed phases sweep the edges of every window, run back-to-back strobes, and toggle enables and modes between sweeps.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int ADDR_W    = 16;
  localparam int NUM_CH    = 2;
  localparam int BAR_BYTES = 20;

  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h07;
  localparam logic [7:0] OFF_PIF  = 8'h09;
  localparam logic [7:0] OFF_BAR  = 8'h10;
  localparam logic [7:0] OFF_GEN  = 8'h4A;

  localparam logic [7:0] CMD_KEEP = 8'h05;
  localparam logic [7:0] GEN_KEEP = 8'h9F;
  localparam logic [7:0] STAT_W1C = 8'h3F;

  function automatic logic [ADDR_W-1:0] legacy_cmd(input int ch);
    return (ch == 0) ? ADDR_W'(16'h01F0) : ADDR_W'(16'h0170);
  endfunction

  function automatic logic [ADDR_W-1:0] legacy_ctl(input int ch);
    return (ch == 0) ? ADDR_W'(16'h03F6) : ADDR_W'(16'h0376);
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [7:0]                cfg_addr,
  input  logic [7:0]                cfg_wdata,
  input  logic [7:0]                stat_set,
  output logic [7:0]                cfg_rdata,
  output logic [7:0]                cmd_q,
  output logic [7:0]                stat_q,
  output logic [7:0]                pif_q,
  output logic [7:0]                gen_q,
  output logic [BAR_BYTES-1:0][7:0] bar_q
);
  logic [7:0]                cmd_d, stat_d, pif_d, gen_d;
  logic [BAR_BYTES-1:0][7:0] bar_d;
  logic                      upd_en;
  logic [7:0]                clr_mask;

  assign upd_en = cfg_we | (|stat_set);

  always_comb begin
    cmd_d    = cmd_q;
    pif_d    = pif_q;
    gen_d    = gen_q;
    bar_d    = bar_q;
    clr_mask = 8'h00;
    if (cfg_we) begin
      if (cfg_addr == OFF_CMD)  cmd_d    = cfg_wdata & CMD_KEEP;
      if (cfg_addr == OFF_PIF)  pif_d    = cfg_wdata;
      if (cfg_addr == OFF_GEN)  gen_d    = cfg_wdata & GEN_KEEP;
      if (cfg_addr == OFF_STAT) clr_mask = cfg_wdata & STAT_W1C;
      for (int i = 0; i < BAR_BYTES; i++) begin
        if (cfg_addr == OFF_BAR + 8'(i)) bar_d[i] = cfg_wdata;
      end
    end
    stat_d = (stat_q & ~clr_mask) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      pif_q  <= '0;
      gen_q  <= '0;
      bar_q  <= '0;
    end else if (upd_en) begin
      cmd_q  <= cmd_d;
      stat_q <= stat_d;
      pif_q  <= pif_d;
      gen_q  <= gen_d;
      bar_q  <= bar_d;
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_addr == OFF_CMD)  cfg_rdata = cmd_q;
    if (cfg_addr == OFF_STAT) cfg_rdata = stat_q;
    if (cfg_addr == OFF_PIF)  cfg_rdata = pif_q;
    if (cfg_addr == OFF_GEN)  cfg_rdata = gen_q;
    for (int i = 0; i < BAR_BYTES; i++) begin
      if (cfg_addr == OFF_BAR + 8'(i)) cfg_rdata = bar_q[i];
    end
  end
endmodule

// File: rtl/ide_chan_dec.sv
module ide_chan_dec
  import ide_dec_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_en,
  input  logic              ch_en,
  input  logic              native,
  input  logic [ADDR_W-1:0] cmd_bar,
  input  logic [ADDR_W-1:0] ctl_bar,
  input  logic              bm_en,
  input  logic [ADDR_W-1:0] bm_bar,
  output logic              cmd_hit,
  output logic              ctl_hit,
  output logic              bm_hit
);
  localparam logic [ADDR_W-1:0] LEG_CMD = legacy_cmd(CH);
  localparam logic [ADDR_W-1:0] LEG_CTL = legacy_ctl(CH);
  localparam logic [ADDR_W-1:0] BM_OFS  = ADDR_W'(CH * 8);

  logic [ADDR_W-1:0] cmd_base, ctl_port, bm_base;

  always_comb begin
    cmd_base = native ? {cmd_bar[ADDR_W-1:3], 3'b000} : LEG_CMD;
    ctl_port = native ? ({ctl_bar[ADDR_W-1:2], 2'b00} + ADDR_W'(2)) : LEG_CTL;
    bm_base  = {bm_bar[ADDR_W-1:4], 4'b0000} + BM_OFS;
    cmd_hit  = io_en & ch_en & (io_addr[ADDR_W-1:3] == cmd_base[ADDR_W-1:3]);
    ctl_hit  = io_en & ch_en & (io_addr == ctl_port);
    bm_hit   = bm_en & (io_addr[ADDR_W-1:3] == bm_base[ADDR_W-1:3]);
  end
endmodule

// File: rtl/ide_io_decode.sv
module ide_io_decode
  import ide_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [7:0]        stat_set,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_strobe,
  output logic [NUM_CH-1:0] cmd_cs,
  output logic [NUM_CH-1:0] ctl_cs,
  output logic [NUM_CH-1:0] bm_cs
);
  logic [7:0]                cmd_q, stat_q, pif_q, gen_q;
  logic [BAR_BYTES-1:0][7:0] bar_q;
  logic [NUM_CH-1:0]         cmd_hit, ctl_hit, bm_hit;
  logic [NUM_CH-1:0]         cmd_d, ctl_d, bm_d;

  ide_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .stat_set  (stat_set),
    .cfg_rdata (cfg_rdata),
    .cmd_q     (cmd_q),
    .stat_q    (stat_q),
    .pif_q     (pif_q),
    .gen_q     (gen_q),
    .bar_q     (bar_q)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ide_chan_dec #(.CH(ch)) u_dec (
      .io_addr (io_addr),
      .io_en   (cmd_q[0]),
      .ch_en   (gen_q[2-ch]),
      .native  (pif_q[2*ch]),
      .cmd_bar ({bar_q[8*ch+1], bar_q[8*ch]}),
      .ctl_bar ({bar_q[8*ch+5], bar_q[8*ch+4]}),
      .bm_en   (cmd_q[2]),
      .bm_bar  ({bar_q[17], bar_q[16]}),
      .cmd_hit (cmd_hit[ch]),
      .ctl_hit (ctl_hit[ch]),
      .bm_hit  (bm_hit[ch])
    );
  end

  always_comb begin
    cmd_d = io_strobe ? cmd_hit : '0;
    ctl_d = io_strobe ? ctl_hit : '0;
    bm_d  = io_strobe ? bm_hit  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_cs <= '0;
      ctl_cs <= '0;
      bm_cs  <= '0;
    end else begin
      cmd_cs <= cmd_d;
      ctl_cs <= ctl_d;
      bm_cs  <= bm_d;
    end
  end
endmodule

// File: rtl/ide_io_decode_chk.sv
module ide_io_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_strobe,
  input logic       cfg_we,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] stat_set,
  input logic [7:0] cmd_q,
  input logic [7:0] stat_q,
  input logic [7:0] gen_q,
  input logic [1:0] cmd_cs,
  input logic [1:0] ctl_cs,
  input logic [1:0] bm_cs
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(io_strobe) |-> (cmd_cs == 2'b00 && ctl_cs == 2'b00 && bm_cs == 2'b00));

  assert_io_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cs != 2'b00 || ctl_cs != 2'b00) |-> $past(cmd_q[0]));

  assert_pri_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cs[0] || ctl_cs[0]) |-> $past(gen_q[2]));

  assert_sec_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cs[1] || ctl_cs[1]) |-> $past(gen_q[1]));

  assert_bm_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_cs != 2'b00) |-> $past(cmd_q[2]));

  assert_cmd_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h04) |=> (cmd_q == ($past(cfg_wdata) & 8'h05)));

  assert_gen_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h4A) |=> (gen_q == ($past(cfg_wdata) & 8'h9F)));

  assert_stat_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h07) |=>
      ((stat_q & $past(cfg_wdata) & 8'h3F & ~$past(stat_set)) == 8'h00));

  assert_stat_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_set != 8'h00) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));
endmodule

bind ide_io_decode ide_io_decode_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_strobe (io_strobe),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .stat_set  (stat_set),
  .cmd_q     (cmd_q),
  .stat_q    (stat_q),
  .gen_q     (gen_q),
  .cmd_cs    (cmd_cs),
  .ctl_cs    (ctl_cs),
  .bm_cs     (bm_cs)
);

// File: tb/ide_io_decode_tb.sv
`timescale 1ns/1ps
module ide_io_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [7:0]  stat_set = 8'h00;
  logic [15:0] io_addr = 16'h0000;
  logic        io_strobe = 1'b0;
  logic [1:0]  cmd_cs, ctl_cs, bm_cs;

  always #2 clk = ~clk;

  ide_io_decode dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stat_set(stat_set),
    .io_addr(io_addr), .io_strobe(io_strobe),
    .cmd_cs(cmd_cs), .ctl_cs(ctl_cs), .bm_cs(bm_cs)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";

  logic [7:0] m_cfg [0:255];
  logic [1:0] e_cmd, e_ctl, e_bm;

  function automatic int word_at(int off);
    return {m_cfg[off+1], m_cfg[off]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_cfg[i] = 8'h00;
      e_cmd = 2'b00; e_ctl = 2'b00; e_bm = 2'b00;
    end else begin
      int a;
      a = int'(io_addr);
      e_cmd = 2'b00; e_ctl = 2'b00; e_bm = 2'b00;
      if (io_strobe) begin
        for (int ch = 0; ch < 2; ch++) begin
          int cb, cp, bb;
          bit nat, en;
          nat = m_cfg[8'h09][2*ch];
          en  = m_cfg[8'h04][0] && m_cfg[8'h4A][2-ch];
          cb  = nat ? (word_at(16 + 8*ch) & 16'hFFF8) : (ch == 0 ? 16'h01F0 : 16'h0170);
          cp  = nat ? ((word_at(20 + 8*ch) & 16'hFFFC) + 2) : (ch == 0 ? 16'h03F6 : 16'h0376);
          bb  = (word_at(32) & 16'hFFF0) + 8*ch;
          if (en && a >= cb && a < cb + 8) e_cmd[ch] = 1'b1;
          if (en && a == cp) e_ctl[ch] = 1'b1;
          if (m_cfg[8'h04][2] && a >= bb && a < bb + 8) e_bm[ch] = 1'b1;
        end
      end
      if (cfg_we) begin
        if (cfg_addr == 8'h04) m_cfg[8'h04] = cfg_wdata & 8'h05;
        if (cfg_addr == 8'h09) m_cfg[8'h09] = cfg_wdata;
        if (cfg_addr == 8'h4A) m_cfg[8'h4A] = cfg_wdata & 8'h9F;
        if (cfg_addr >= 8'h10 && cfg_addr <= 8'h23) m_cfg[cfg_addr] = cfg_wdata;
        if (cfg_addr == 8'h07) m_cfg[8'h07] = m_cfg[8'h07] & ~(cfg_wdata & 8'h3F);
      end
      m_cfg[8'h07] = m_cfg[8'h07] | stat_set;
    end
  end

  task automatic cmp8(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act %h exp %h", cur_tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cmp8("cmd_cs", {6'b0, cmd_cs}, {6'b0, e_cmd});
    cmp8("ctl_cs", {6'b0, ctl_cs}, {6'b0, e_ctl});
    cmp8("bm_cs",  {6'b0, bm_cs},  {6'b0, e_bm});
    cmp8("cfg_rdata", cfg_rdata, m_cfg[cfg_addr]);
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); cfg_addr = a;
    @(negedge clk);
  endtask

  task automatic sweep(int lo, int hi);
    for (int a = lo; a <= hi; a++) begin
      @(negedge clk); io_addr = 16'(a); io_strobe = 1'b1;
    end
    @(negedge clk); io_strobe = 1'b0;
  endtask

  task automatic legacy_sweeps();
    sweep(16'h01EF, 16'h01F8);
    sweep(16'h03F5, 16'h03F7);
    sweep(16'h016F, 16'h0178);
    sweep(16'h0375, 16'h0377);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h04); rd(8'h09); rd(8'h10); rd(8'h4A); rd(8'h07);
    legacy_sweeps();

    cur_tag = "R2";
    wr(8'h4A, 8'h06);
    legacy_sweeps();

    cur_tag = "R9";
    wr(8'h04, 8'hFF); rd(8'h04);
    wr(8'h4A, 8'hFF); rd(8'h4A);
    wr(8'h30, 8'h5A); rd(8'h30);
    wr(8'h0D, 8'h77); rd(8'h0D);
    wr(8'h04, 8'h01);

    cur_tag = "R3";
    wr(8'h4A, 8'h00); legacy_sweeps();
    wr(8'h4A, 8'h04); legacy_sweeps();
    wr(8'h4A, 8'h02); legacy_sweeps();

    cur_tag = "R4";
    wr(8'h4A, 8'h06); legacy_sweeps();

    cur_tag = "R5";
    wr(8'h10, 8'h47); wr(8'h11, 8'h12);
    wr(8'h18, 8'h80); wr(8'h19, 8'hAB);
    wr(8'h14, 8'h57); wr(8'h15, 8'h13);
    wr(8'h1C, 8'h0E); wr(8'h1D, 8'hAC);
    wr(8'h09, 8'h05); rd(8'h11);
    sweep(16'h123E, 16'h1249);
    sweep(16'hAB7F, 16'hAB88);
    legacy_sweeps();

    cur_tag = "R6";
    sweep(16'h1353, 16'h1357);
    sweep(16'hAC0B, 16'hAC0F);

    cur_tag = "R4";
    wr(8'h09, 8'h01);
    sweep(16'h1240, 16'h1247);
    sweep(16'hAB80, 16'hAB81);
    legacy_sweeps();

    cur_tag = "R7";
    wr(8'h20, 8'h3D); wr(8'h21, 8'hD0);
    sweep(16'hD02E, 16'hD041);
    wr(8'h04, 8'h04);
    sweep(16'hD02E, 16'hD041);
    sweep(16'h1240, 16'h1241);
    wr(8'h04, 8'h05);
    sweep(16'hD036, 16'hD039);

    cur_tag = "R8";
    @(negedge clk); io_addr = 16'h1240; io_strobe = 1'b0;
    repeat (3) @(negedge clk);
    io_addr = 16'hD030; repeat (2) @(negedge clk);
    io_strobe = 1'b1; @(negedge clk);
    io_addr = 16'h1244; @(negedge clk);
    io_strobe = 1'b0; @(negedge clk);
    @(negedge clk); io_strobe = 1'b1; io_addr = 16'h1240;
    cfg_we = 1'b1; cfg_addr = 8'h04; cfg_wdata = 8'h00;
    @(negedge clk); cfg_we = 1'b0; io_addr = 16'h1241;
    @(negedge clk); io_strobe = 1'b0;

    cur_tag = "R10";
    @(negedge clk); cfg_addr = 8'h07; stat_set = 8'hFF;
    @(negedge clk); stat_set = 8'h00;
    @(negedge clk);
    wr(8'h07, 8'hFF);
    rd(8'h07);
    @(negedge clk); stat_set = 8'h03;
    @(negedge clk); stat_set = 8'h00;
    wr(8'h07, 8'h01);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'h07; cfg_wdata = 8'h02; stat_set = 8'h02;
    @(negedge clk); cfg_we = 1'b0; stat_set = 8'h00;
    rd(8'h07);
    rd(8'h08);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule